// File: doc/BRIEF.md
# PWM Dither Offset Unit

This block sits beside a PWM counter and perturbs the values that counter compares against. It adds a small pseudo-random offset to the base period value and to the two base compare values. Over many PWM cycles the switching edges move slightly, which spreads the output spectrum instead of concentrating it at one frequency. Two independent 8-bit linear feedback shift registers produce the offsets. One drives the period path and the other drives the duty path. The duty offset is shared by both compare values, so the two compare edges of a cycle move together.

Software supplies a nonzero seed for each generator and pulses the load strobe. The counter pulses the advance strobe on every terminal count. A 2-bit mode chooses which paths receive an offset. A 3-bit limiter decides how many low bits of each generator reach the adder. Each sum saturates at the counter's full scale. The outputs are combinational functions of the base inputs and the generator state, so the counter sees a new base value in the same cycle it is applied.

Top module: `pwm_dither_unit`

## Requirements
- R1: After reset both generators hold the value 1, so with mode 3, limiter 7 and all bases 0 the three outputs read 1.
- R2: Mode bit 0 enables the period offset and mode bit 1 enables the duty offset. Mode 0 dithers nothing, 1 dithers only the period, 2 dithers only the duty values and 3 dithers both. A disabled output equals its base input in the same cycle.
- R3: When the load strobe is high, each generator takes its own seed at the next clock edge, and a zero seed is replaced by 1. Load takes priority over an advance strobe given in the same cycle.
- R4: When the advance strobe is high and load is low, each generator steps once: the new state is the old state shifted up by one bit, and the bit shifted in is bit7 XOR bit5 XOR bit4 XOR bit3 (taps 8,6,5,4). Both generators step in every mode, and neither changes when both strobes are low.
- R5: With limiter value L, the offset is the generator state masked to its low L bits. L = 0 gives a zero offset.
- R6: The duty offset is added to both compare values, CC0 and CC1.
- R7: A sum that would exceed 2^CNT_W-1 saturates at 2^CNT_W-1 rather than wrapping.
- R8: The outputs follow the base inputs, mode and limiter combinationally, with no clock of latency.
- R9: A generator never holds zero, and when it is seeded with 1 it returns to 1 after exactly 255 advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Dither select: bit 0 for period, bit 1 for duty |
| limit | input | 3 | Number of generator bits used as the offset (0..7) |
| per_seed | input | 8 | Seed for the period generator |
| duty_seed | input | 8 | Seed for the duty generator |
| load | input | 1 | Loads both seeds |
| tc_adv | input | 1 | Terminal-count strobe that advances both generators |
| base_period | input | CNT_W | Undithered period value |
| base_cc0 | input | CNT_W | Undithered compare 0 value |
| base_cc1 | input | CNT_W | Undithered compare 1 value |
| dith_period | output | CNT_W | Period after dithering |
| dith_cc0 | output | CNT_W | Compare 0 after dithering |
| dith_cc1 | output | CNT_W | Compare 1 after dithering |

## Verification
Random stimulus varies the mode, the limiter, the strobes and the base values. Some bases are placed near full scale so that saturating sums can be told apart from wrapping ones. A bypassed path is told apart from a dithered one by using nonzero bases, and comparing CC0 with CC1 shows whether they share one offset. Directed cases cover the following:
- a zero seed, which reveals whether the generator can lock up;
- load and advance in the same cycle, which reveals priority;
- one hand-computed step from a known seed, which confirms the taps;
- a full 255-step walk, which shows whether the sequence is maximal length;
- limiter 0, which must give no offset;
- a base change with no clock edge, which shows whether the outputs carry latency.

// File: rtl/pwm_dither_pkg.sv
package pwm_dither_pkg;

   typedef enum logic [1:0] {
      DM_NONE   = 2'd0,
      DM_PERIOD = 2'd1,
      DM_DUTY   = 2'd2,
      DM_BOTH   = 2'd3
   } dither_mode_e;

   localparam int unsigned PATH_PER  = 0;
   localparam int unsigned PATH_DUTY = 1;
   localparam int unsigned NUM_PATHS = 2;
   localparam int unsigned NUM_CHANS = 3;

   // Feedback tap mask per supported generator width (bit i = stage i+1).
   function automatic logic [31:0] tap_mask(input int unsigned w);
      case (w)
         8:       tap_mask = 32'h0000_00B8;
         default: tap_mask = 32'h0;
      endcase
   endfunction

   // Source path feeding each output channel: period, cc0, cc1.
   function automatic int unsigned chan_path(input int unsigned ch);
      chan_path = (ch == 0) ? PATH_PER : PATH_DUTY;
   endfunction

endpackage

// File: rtl/dither_lfsr.sv
module dither_lfsr #(
   parameter int unsigned          W    = 8,
   parameter logic [W-1:0]         TAPS = 8'hB8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic         adv,
   output logic [W-1:0] state
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic         fb;
   logic [W-1:0] nxt;
   logic [W-1:0] seed_safe;

   generate
      if (W < 3) begin : g_bad_w
         $error("dither_lfsr: width must be at least 3");
      end
      if (TAPS == '0) begin : g_bad_taps
         $error("dither_lfsr: no feedback taps for this width");
      end
   endgenerate

   always_comb begin
      fb        = ^(state & TAPS);
      nxt       = {state[W-2:0], fb};
      seed_safe = (seed == '0) ? ONE : seed;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ONE;
      end else if (load) begin
         state <= seed_safe;
      end else if (adv) begin
         state <= nxt;
      end
   end
endmodule

// File: rtl/dither_mask.sv
module dither_mask #(
   parameter int unsigned W  = 8,
   parameter int unsigned LW = 3
) (
   input  logic [LW-1:0] limit,
   input  logic [W-1:0]  value,
   output logic [W-1:0]  masked
);
   logic [W-1:0] keep;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign keep[i] = (int'(limit) > i);
      end
   endgenerate

   assign masked = value & keep;
endmodule

// File: rtl/dither_sat_add.sv
module dither_sat_add #(
   parameter int unsigned CW = 16,
   parameter int unsigned OW = 8
) (
   input  logic          en,
   input  logic [CW-1:0] base,
   input  logic [OW-1:0] off,
   output logic [CW-1:0] result
);
   localparam int unsigned PADW = CW + 1 - OW;

   logic [CW:0] sum;

   always_comb begin
      sum = {1'b0, base} + {{PADW{1'b0}}, off};
      if (!en) begin
         result = base;
      end else if (sum[CW]) begin
         result = '1;
      end else begin
         result = sum[CW-1:0];
      end
   end
endmodule

// File: rtl/pwm_dither_unit.sv
module pwm_dither_unit #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned LFSR_W = 8,
   parameter int unsigned LIM_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic [LIM_W-1:0]  limit,
   input  logic [LFSR_W-1:0] per_seed,
   input  logic [LFSR_W-1:0] duty_seed,
   input  logic              load,
   input  logic              tc_adv,
   input  logic [CNT_W-1:0]  base_period,
   input  logic [CNT_W-1:0]  base_cc0,
   input  logic [CNT_W-1:0]  base_cc1,
   output logic [CNT_W-1:0]  dith_period,
   output logic [CNT_W-1:0]  dith_cc0,
   output logic [CNT_W-1:0]  dith_cc1
);
   import pwm_dither_pkg::*;

   localparam logic [LFSR_W-1:0] TAPS = LFSR_W'(tap_mask(LFSR_W));

   generate
      if (CNT_W < LFSR_W) begin : g_bad_cnt
         $error("pwm_dither_unit: counter narrower than generator");
      end
      if (tap_mask(LFSR_W) == 0) begin : g_bad_lfsr
         $error("pwm_dither_unit: unsupported generator width");
      end
   endgenerate

   logic [LFSR_W-1:0] seeds    [NUM_PATHS];
   logic [LFSR_W-1:0] gen_st   [NUM_PATHS];
   logic [LFSR_W-1:0] gen_off  [NUM_PATHS];
   logic [NUM_PATHS-1:0] path_en;
   logic [CNT_W-1:0]  ch_base  [NUM_CHANS];
   logic [CNT_W-1:0]  ch_out   [NUM_CHANS];

   // Generator states, exposed by name for the bound checker.
   logic [LFSR_W-1:0] per_state;
   logic [LFSR_W-1:0] duty_state;

   always_comb begin
      seeds[PATH_PER]    = per_seed;
      seeds[PATH_DUTY]   = duty_seed;
      path_en[PATH_PER]  = mode[0];
      path_en[PATH_DUTY] = mode[1];
      ch_base[0]         = base_period;
      ch_base[1]         = base_cc0;
      ch_base[2]         = base_cc1;
      per_state          = gen_st[PATH_PER];
      duty_state         = gen_st[PATH_DUTY];
   end

   generate
      for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
         dither_lfsr #(
            .W    (LFSR_W),
            .TAPS (TAPS)
         ) lfsr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .seed  (seeds[p]),
            .adv   (tc_adv),
            .state (gen_st[p])
         );

         dither_mask #(
            .W  (LFSR_W),
            .LW (LIM_W)
         ) mask_i (
            .limit  (limit),
            .value  (gen_st[p]),
            .masked (gen_off[p])
         );
      end

      for (genvar c = 0; c < NUM_CHANS; c++) begin : g_chan
         localparam int unsigned SRC = chan_path(c);
         dither_sat_add #(
            .CW (CNT_W),
            .OW (LFSR_W)
         ) add_i (
            .en     (path_en[SRC]),
            .base   (ch_base[c]),
            .off    (gen_off[SRC]),
            .result (ch_out[c])
         );
      end
   endgenerate

   assign dith_period = ch_out[0];
   assign dith_cc0    = ch_out[1];
   assign dith_cc1    = ch_out[2];
endmodule

// File: rtl/pwm_dither_unit_chk.sv
module pwm_dither_unit_chk #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned LFSR_W = 8,
   parameter int unsigned LIM_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic [LIM_W-1:0]  limit,
   input logic [LFSR_W-1:0] per_seed,
   input logic [LFSR_W-1:0] duty_seed,
   input logic              load,
   input logic              tc_adv,
   input logic [CNT_W-1:0]  base_period,
   input logic [CNT_W-1:0]  base_cc0,
   input logic [CNT_W-1:0]  base_cc1,
   input logic [CNT_W-1:0]  dith_period,
   input logic [CNT_W-1:0]  dith_cc0,
   input logic [CNT_W-1:0]  dith_cc1,
   input logic [LFSR_W-1:0] per_state,
   input logic [LFSR_W-1:0] duty_state
);
   localparam logic [CNT_W-1:0] HEADROOM = CNT_W'((1 << LFSR_W) - 1);
   localparam logic [CNT_W-1:0] TOP      = '1;

   logic [CNT_W-1:0] lim_cap;
   logic [CNT_W-1:0] per_delta, cc0_delta, cc1_delta;

   always_comb begin
      lim_cap   = CNT_W'((1 << limit) - 1);
      per_delta = dith_period - base_period;
      cc0_delta = dith_cc0 - base_cc0;
      cc1_delta = dith_cc1 - base_cc1;
   end

   a_r2_period_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      !mode[0] |-> dith_period == base_period);
   a_r2_duty_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      !mode[1] |-> (dith_cc0 == base_cc0) && (dith_cc1 == base_cc1));
   a_r3_load_per: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> per_state == (($past(per_seed) == '0) ? LFSR_W'(1) : $past(per_seed)));
   a_r3_load_duty: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> duty_state == (($past(duty_seed) == '0) ? LFSR_W'(1) : $past(duty_seed)));
   a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tc_adv) |=> $stable(per_state) && $stable(duty_state));
   a_r4_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && tc_adv) |=> per_state[LFSR_W-1:1] == $past(per_state[LFSR_W-2:0]));
   a_r5_offset_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (per_delta <= lim_cap) && (cc0_delta <= lim_cap) && (cc1_delta <= lim_cap));
   a_r6_shared_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] && base_cc0 <= TOP - HEADROOM && base_cc1 <= TOP - HEADROOM)
      |-> cc0_delta == cc1_delta);
   a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (dith_period >= base_period) && (dith_cc0 >= base_cc0) && (dith_cc1 >= base_cc1));
   a_r9_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (per_state != '0) && (duty_state != '0));
endmodule

bind pwm_dither_unit pwm_dither_unit_chk #(
   .CNT_W  (CNT_W),
   .LFSR_W (LFSR_W),
   .LIM_W  (LIM_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode        (mode),
   .limit       (limit),
   .per_seed    (per_seed),
   .duty_seed   (duty_seed),
   .load        (load),
   .tc_adv      (tc_adv),
   .base_period (base_period),
   .base_cc0    (base_cc0),
   .base_cc1    (base_cc1),
   .dith_period (dith_period),
   .dith_cc0    (dith_cc0),
   .dith_cc1    (dith_cc1),
   .per_state   (per_state),
   .duty_state  (duty_state)
);

// File: tb/pwm_dither_unit_tb_top.sv
`timescale 1ns/1ps
module pwm_dither_unit_tb_top;
   localparam int CW = 16;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = '0;
   logic [2:0]    limit = '0;
   logic [LW-1:0] per_seed = '0, duty_seed = '0;
   logic          load = 1'b0, tc_adv = 1'b0;
   logic [CW-1:0] base_period = '0, base_cc0 = '0, base_cc1 = '0;
   logic [CW-1:0] dith_period, dith_cc0, dith_cc1;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [LW-1:0] m_per = 8'd1, m_duty = 8'd1;

   always #5 clk = ~clk;

   pwm_dither_unit #(.CNT_W(CW), .LFSR_W(LW), .LIM_W(3)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode(mode), .limit(limit),
      .per_seed(per_seed), .duty_seed(duty_seed), .load(load), .tc_adv(tc_adv),
      .base_period(base_period), .base_cc0(base_cc0), .base_cc1(base_cc1),
      .dith_period(dith_period), .dith_cc0(dith_cc0), .dith_cc1(dith_cc1));

   function automatic logic [LW-1:0] f_next(input logic [LW-1:0] s);
      return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
   endfunction

   function automatic logic [LW-1:0] f_seed(input logic [LW-1:0] s);
      return (s == 0) ? 8'd1 : s;
   endfunction

   function automatic logic [CW-1:0] f_exp(input logic [CW-1:0] b, input logic [LW-1:0] st,
                                           input logic en, input logic [2:0] lim);
      logic [LW-1:0] off;
      logic [CW:0]   sum;
      off = st & LW'((1 << lim) - 1);
      sum = {1'b0, b} + CW'(off);
      if (!en) return b;
      return sum[CW] ? '1 : sum[CW-1:0];
   endfunction

   task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic en, input logic [CW-1:0] b,
                                    input logic [CW-1:0] e, input string dflt);
      if (!en) return "R2";
      if (e == '1 && b != '1) return "R7";
      return dflt;
   endfunction

   task automatic check_all();
      logic [CW-1:0] ep, e0, e1;
      #1;
      ep = f_exp(base_period, m_per, mode[0], limit);
      e0 = f_exp(base_cc0, m_duty, mode[1], limit);
      e1 = f_exp(base_cc1, m_duty, mode[1], limit);
      chk(tag_of(mode[0], base_period, ep, "R5"), dith_period, ep);
      chk(tag_of(mode[1], base_cc0, e0, "R6"), dith_cc0, e0);
      chk(tag_of(mode[1], base_cc1, e1, "R6"), dith_cc1, e1);
   endtask

   // One clock edge; the bench model follows the strobes it drove.
   task automatic tick();
      @(posedge clk);
      if (load) begin
         m_per  = f_seed(per_seed);
         m_duty = f_seed(duty_seed);
      end else if (tc_adv) begin
         m_per  = f_next(m_per);
         m_duty = f_next(m_duty);
      end
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      mode = 2'd3; limit = 3'd7;
      #1;
      chk("R1", dith_period, 16'd1);
      chk("R1", dith_cc0, 16'd1);
      chk("R1", dith_cc1, 16'd1);

      // R3: load, zero seed replaced by 1
      per_seed = 8'h5A; duty_seed = 8'h00; load = 1'b1;
      tick();
      load = 1'b0;
      #1;
      chk("R3", dith_period, 16'h005A);
      chk("R3", dith_cc0, 16'h0001);

      // R4: one step from 0x5A gives 0xB4, low seven bits 0x34
      tc_adv = 1'b1;
      tick();
      tc_adv = 1'b0;
      #1;
      chk("R4", dith_period, 16'h0034);
      // R4: no strobe, no change
      tick();
      chk("R4", dith_period, 16'h0034);

      // R3: load beats advance
      per_seed = 8'h11; load = 1'b1; tc_adv = 1'b1;
      tick();
      load = 1'b0; tc_adv = 1'b0;
      #1;
      chk("R3", dith_period, 16'h0011);

      // R5: limiter 0 and 3
      @(negedge clk);
      base_period = 16'h0100; base_cc0 = 16'h0200; base_cc1 = 16'h0300;
      limit = 3'd0;
      #1;
      chk("R5", dith_period, 16'h0100);
      limit = 3'd3;
      #1;
      chk("R5", dith_period, 16'h0101);

      // R2: each mode
      for (int m = 0; m < 4; m++) begin
         mode = 2'(m);
         check_all();
      end

      // R7: saturation
      mode = 2'd3; limit = 3'd7;
      base_period = 16'hFFFF; base_cc0 = 16'hFFFE; base_cc1 = 16'h0000;
      duty_seed = 8'h7F; load = 1'b1;
      tick();
      load = 1'b0;
      #1;
      chk("R7", dith_period, 16'hFFFF);
      chk("R7", dith_cc0, 16'hFFFF);
      chk("R6", dith_cc1, 16'h007F);

      // R8: base change without an edge
      base_period = 16'h1000;
      #1;
      chk("R8", dith_period, 16'h1011);

      // R9: sequence length 255 from seed 1
      @(negedge clk);
      per_seed = 8'h01; load = 1'b1; base_period = '0;
      tick();
      load = 1'b0; tc_adv = 1'b1;
      for (int i = 0; i < 255; i++) tick();
      tc_adv = 1'b0;
      #1;
      chk("R9", dith_period, 16'h0001);
      chk("R4", dith_cc1, f_exp(base_cc1, m_duty, 1'b1, 3'd7));

      // Random phase
      for (int i = 0; i < 3000; i++) begin
         mode   = 2'($urandom_range(0, 3));
         limit  = 3'($urandom_range(0, 7));
         load   = ($urandom_range(0, 19) == 0);
         tc_adv = ($urandom_range(0, 2) != 0);
         per_seed  = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
         duty_seed = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
         base_period = ($urandom_range(0, 3) == 0) ? 16'hFFFF - 16'($urandom_range(0, 100)) : 16'($urandom);
         base_cc0    = ($urandom_range(0, 3) == 0) ? 16'hFFFF - 16'($urandom_range(0, 100)) : 16'($urandom);
         base_cc1    = 16'($urandom);
         check_all();
         tick();
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule